// File: doc/BRIEF.md
# Random Word Generator with Register Front End

This block turns a pseudo-random bit stream into 32-bit words and offers them to software through a small register bus. A 32-bit Galois LFSR stands in for a true entropy source. At a programmable rate, set by a divider, it produces one bit per sample. A saturating counter tracks every sampled bit. Bits sampled before that count reaches a programmable warm-up threshold are thrown away. Later bits are packed MSB-first into words and pushed into a 16-entry word FIFO.

Software reads the oldest word from the data register. It watches the FIFO level and an interrupt status register to decide when to read. Two independent soft resets are provided. One clears the sampling core, meaning the FIFO and the bit counter. The other returns the generator to its seed. A `health_fail` input stands in for statistical health tests. It sets a sticky fail flag, and a repeat failure sets a lockout that halts sampling. Both flags stay set until software clears them by writing ones.

Top module: `rng_regfront`

## Requirements
- R1: After reset every register reads zero, the FIFO is empty and `irq` is low.
- R2: Sampling runs while any bit of control[12:0] is set, neither soft reset is held and lockout is clear. With divider 0 it takes one bit per clock, and register 0x0C counts every sampled bit.
- R3: The generator state resets to 0xACE12345. Each sample outputs state bit 31 and then steps the state to (state<<1) XOR (0x04C11DB7 if bit 31 was set). The first N sampled bits are discarded, where N is the threshold at 0x10. Each later group of 32 bits forms one word, with the earliest bit in bit 31.
- R4: A read of 0x20 returns the oldest word and removes it. A read of an empty FIFO returns zero and leaves the level at zero. The level is in 0x24[7:0].
- R5: The FIFO holds 16 words. Words completed while it is full are dropped, and the stored words are kept in order.
- R6: Clearing the enable field stops sampling. It keeps both the FIFO contents and the partially gathered word, so the bit stream continues unbroken on re-enable.
- R7: While bit 0 of 0x04 is set, the FIFO is empty and the bit count is zero. While bit 0 of 0x08 is set, the generator is held at its seed.
- R8: Control bits [20:13] hold a divider D. One sample is taken every D+1 clocks.
- R9: Status (0x18) bit 0 is set on the sample that brings the count equal to a nonzero threshold. Bit 17 is set on the sample that takes the count from 16 to 17. Writing a one to a status bit clears it.
- R10: `health_fail` sets status bit 5. If it is asserted while bit 5 is already set, it also sets bit 31 (lockout). Lockout halts sampling. Both bits stay set until cleared by writing ones.
- R11: 0x24[15:8] holds a level threshold T. Status bit 1 reads one while T is nonzero and the level is at least T, and writing a one does not clear it. `irq` is the OR of status AND the enable register at 0x1C.
- R12: The bit count saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of 0x20 pops the FIFO) |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle the read strobe is high |
| health_fail | input | 1 | Health-test failure indication |
| irq | output | 1 | Interrupt request |

## Verification
The bench regenerates the expected words from the stated polynomial and seed. A design that packs LSB-first, shifts a threshold off by one bit, or loses the partial word when enable drops returns wrong data words. It overfills the FIFO and reads an empty FIFO. A design that wraps its pointers or counts underflow would then show stray words or a level other than 0 or 16. It drives a repeat health failure and then tries to sample. A design that failed to lock out, or that let the write-one-to-clear reach the live level bit, would show a moving bit count or a wrong status word. The bench is built with a narrowed counter, so saturation is reached in a short run.

// File: rtl/rng_front_pkg.sv
package rng_front_pkg;

  localparam int WORD_W = 32;

  localparam logic [7:0] A_CTRL     = 8'h00;
  localparam logic [7:0] A_CORE_RST = 8'h04;
  localparam logic [7:0] A_GEN_RST  = 8'h08;
  localparam logic [7:0] A_BITCNT   = 8'h0C;
  localparam logic [7:0] A_WARM     = 8'h10;
  localparam logic [7:0] A_ISTAT    = 8'h18;
  localparam logic [7:0] A_IEN      = 8'h1C;
  localparam logic [7:0] A_DATA     = 8'h20;
  localparam logic [7:0] A_LEVEL    = 8'h24;

  localparam int ST_TOTAL = 0;
  localparam int ST_LEVEL = 1;
  localparam int ST_HFAIL = 5;
  localparam int ST_WARM  = 17;
  localparam int ST_LOCK  = 31;

  localparam int EN_W    = 13;
  localparam int DIV_LSB = 13;
  localparam int DIV_W   = 8;

  localparam logic [WORD_W-1:0] LFSR_TAPS = 32'h04C1_1DB7;
  localparam logic [WORD_W-1:0] LFSR_SEED = 32'hACE1_2345;

  function automatic logic [WORD_W-1:0] lfsr_step(input logic [WORD_W-1:0] s);
    return {s[WORD_W-2:0], 1'b0} ^ (s[WORD_W-1] ? LFSR_TAPS : '0);
  endfunction

  function automatic logic [WORD_W-1:0] pack_bit(input logic [WORD_W-1:0] w, input logic b);
    return {w[WORD_W-2:0], b};
  endfunction

  function automatic logic [WORD_W-1:0] status_word(input logic lock, input logic warm,
                                                    input logic hfail, input logic lvl,
                                                    input logic total);
    logic [WORD_W-1:0] s;
    s = '0;
    s[ST_LOCK]  = lock;
    s[ST_WARM]  = warm;
    s[ST_HFAIL] = hfail;
    s[ST_LEVEL] = lvl;
    s[ST_TOTAL] = total;
    return s;
  endfunction

endpackage

// File: rtl/rng_bitsrc.sv
module rng_bitsrc
  import rng_front_pkg::*;
#(
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          tick,
  output logic          bit_o
);

  logic [WORD_W-1:0] lfsr_q;
  logic [DW-1:0]     dcnt_q;

  assign tick  = run && !hold && (dcnt_q == div);
  assign bit_o = lfsr_q[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= LFSR_SEED;
      dcnt_q <= '0;
    end else if (hold) begin
      lfsr_q <= LFSR_SEED;
      dcnt_q <= '0;
    end else if (!run) begin
      dcnt_q <= '0;
    end else if (dcnt_q == div) begin
      dcnt_q <= '0;
      lfsr_q <= lfsr_step(lfsr_q);
    end else begin
      dcnt_q <= dcnt_q + 1'b1;
    end
  end

  // R8: after a sample the next one is at least div+1 clocks away (div>0 case: no back-to-back)
  a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && $stable(div)) |=> !tick);

  // R7: generator held at its seed during its soft reset
  a_r7_gen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (lfsr_q == LFSR_SEED));

endmodule

// File: rtl/rng_packer.sv
module rng_packer
  import rng_front_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_cnt,
  input  logic              clr_word,
  input  logic              tick,
  input  logic              bit_i,
  input  logic [CNT_W-1:0]  warm_thr,
  output logic [CNT_W-1:0]  total_cnt,
  output logic              warm_hit,
  output logic              start_hit,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);

  localparam int               NB_W    = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] START_N = CNT_W'(16);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shreg_q;
  logic [NB_W-1:0]   nbits_q;
  logic              accept;

  assign total_cnt = cnt_q;
  assign accept    = tick && (cnt_q >= warm_thr);
  assign warm_hit  = tick && (warm_thr != '0) && (cnt_q != warm_thr) && (sat_inc(cnt_q) == warm_thr);
  assign start_hit = tick && (cnt_q == START_N);
  assign word_vld  = accept && (nbits_q == NB_W'(WORD_W - 1));
  assign word      = pack_bit(shreg_q, bit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr_cnt)    cnt_q <= '0;
    else if (tick)       cnt_q <= sat_inc(cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      nbits_q <= '0;
    end else if (clr_word) begin
      shreg_q <= '0;
      nbits_q <= '0;
    end else if (accept) begin
      shreg_q <= word;
      nbits_q <= nbits_q + 1'b1;
    end
  end

  // R12: count holds at all-ones
  a_r12_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr_cnt) |=> (cnt_q == CNT_MAX));

  // R3: bits below the warm-up threshold never enter the partial word
  a_r3_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q < warm_thr && !clr_word) |=> (nbits_q == $past(nbits_q)));

  // R2: count moves by at most one per clock
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_cnt && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/rng_fifo.sv
module rng_fifo
  import rng_front_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [WORD_W-1:0] din,
  input  logic              pop,
  output logic [WORD_W-1:0] dout,
  output logic [$clog2(DEPTH+1)-1:0] level
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     wr_q, rd_q;
  logic [LW-1:0]     lvl_q;
  logic              full, empty, do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (lvl_q == LW'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = empty ? '0 : mem_q[rd_q];
  assign level   = lvl_q;

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem_q[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else if (flush) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) wr_q <= ptr_inc(wr_q);
      if (do_pop)  rd_q <= ptr_inc(rd_q);
      if (do_push && !do_pop)      lvl_q <= lvl_q + 1'b1;
      else if (do_pop && !do_push) lvl_q <= lvl_q - 1'b1;
    end
  end

  // R5: never exceeds depth
  a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LW'(DEPTH));

  // R5: a push into a full FIFO is dropped
  a_r5_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (lvl_q == LW'(DEPTH)));

  // R4: a pop of an empty FIFO leaves it empty
  a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> (lvl_q == '0));

endmodule

// File: rtl/rng_regfront.sv
module rng_regfront
  import rng_front_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        health_fail,
  output logic        irq
);

  localparam int LW = $clog2(FIFO_DEPTH + 1);

  // registers
  logic [EN_W-1:0]  en_q;
  logic [DIV_W-1:0] div_q;
  logic             core_rst_q, gen_rst_q;
  logic [CNT_W-1:0] warm_thr_q;
  logic [31:0]      ien_q;
  logic [7:0]       lvl_thr_q;
  logic             st_total_q, st_warm_q, st_hfail_q, st_lock_q;

  // named internal events
  logic             run, tick, src_bit;
  logic             warm_hit, start_hit, word_vld;
  logic [WORD_W-1:0] word, fifo_dout;
  logic [CNT_W-1:0] total_cnt;
  logic [LW-1:0]    level;
  logic             level_live, pop_req;
  logic             wr_ctrl, wr_core, wr_gen, wr_warm, wr_stat, wr_ien, wr_lvl;
  logic [31:0]      stat;

  assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
  assign wr_core = bus_wr && bus_addr == A_CORE_RST;
  assign wr_gen  = bus_wr && bus_addr == A_GEN_RST;
  assign wr_warm = bus_wr && bus_addr == A_WARM;
  assign wr_stat = bus_wr && bus_addr == A_ISTAT;
  assign wr_ien  = bus_wr && bus_addr == A_IEN;
  assign wr_lvl  = bus_wr && bus_addr == A_LEVEL;
  assign pop_req = bus_rd && bus_addr == A_DATA;

  assign run = (en_q != '0) && !core_rst_q && !st_lock_q;

  rng_bitsrc #(.DW(DIV_W)) u_src (
    .clk(clk), .rst_n(rst_n), .hold(gen_rst_q), .run(run),
    .div(div_q), .tick(tick), .bit_o(src_bit)
  );

  rng_packer #(.CNT_W(CNT_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr_cnt(core_rst_q), .clr_word(core_rst_q || gen_rst_q),
    .tick(tick), .bit_i(src_bit), .warm_thr(warm_thr_q), .total_cnt(total_cnt),
    .warm_hit(warm_hit), .start_hit(start_hit), .word_vld(word_vld), .word(word)
  );

  rng_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(core_rst_q), .push(word_vld), .din(word),
    .pop(pop_req), .dout(fifo_dout), .level(level)
  );

  assign level_live = (lvl_thr_q != '0) && (8'(level) >= lvl_thr_q);
  assign stat       = status_word(st_lock_q, st_warm_q, st_hfail_q, level_live, st_total_q);
  assign irq        = |(stat & ien_q);

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= '0;
      div_q      <= '0;
      core_rst_q <= 1'b0;
      gen_rst_q  <= 1'b0;
      warm_thr_q <= '0;
      ien_q      <= '0;
      lvl_thr_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= bus_wdata[EN_W-1:0];
        div_q <= bus_wdata[DIV_LSB +: DIV_W];
      end
      if (wr_core) core_rst_q <= bus_wdata[0];
      if (wr_gen)  gen_rst_q  <= bus_wdata[0];
      if (wr_warm) warm_thr_q <= bus_wdata[CNT_W-1:0];
      if (wr_ien)  ien_q      <= bus_wdata;
      if (wr_lvl)  lvl_thr_q  <= bus_wdata[15:8];
    end
  end

  // sticky status, set wins over write-one-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_total_q <= 1'b0;
      st_warm_q  <= 1'b0;
      st_hfail_q <= 1'b0;
      st_lock_q  <= 1'b0;
    end else begin
      if (warm_hit)                           st_total_q <= 1'b1;
      else if (wr_stat && bus_wdata[ST_TOTAL]) st_total_q <= 1'b0;
      if (start_hit)                          st_warm_q  <= 1'b1;
      else if (wr_stat && bus_wdata[ST_WARM])  st_warm_q  <= 1'b0;
      if (health_fail)                        st_hfail_q <= 1'b1;
      else if (wr_stat && bus_wdata[ST_HFAIL]) st_hfail_q <= 1'b0;
      if (health_fail && st_hfail_q)          st_lock_q  <= 1'b1;
      else if (wr_stat && bus_wdata[ST_LOCK])  st_lock_q  <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL:     bus_rdata = 32'({div_q, en_q});
      A_CORE_RST: bus_rdata = {31'b0, core_rst_q};
      A_GEN_RST:  bus_rdata = {31'b0, gen_rst_q};
      A_BITCNT:   bus_rdata = 32'(total_cnt);
      A_WARM:     bus_rdata = 32'(warm_thr_q);
      A_ISTAT:    bus_rdata = stat;
      A_IEN:      bus_rdata = ien_q;
      A_DATA:     bus_rdata = fifo_dout;
      A_LEVEL:    bus_rdata = {16'b0, lvl_thr_q, 8'(level)};
      default:    bus_rdata = '0;
    endcase
  end

  // R10: lockout halts sampling
  a_r10_lock_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (st_lock_q && !core_rst_q) |=> (total_cnt == $past(total_cnt)));

  // R10: lockout is sticky until written with a one
  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_lock_q && !(wr_stat && bus_wdata[ST_LOCK])) |=> st_lock_q);

  // R6: no sampling with the enable field clear
  a_r6_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !tick);

  // R11: an interrupt needs some enabled bit
  a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q != '0));

  // R7: core soft reset empties the FIFO
  a_r7_core_flush: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_q |=> (level == '0));

endmodule

// File: tb/tb_rng_regfront.sv
module tb_rng_regfront;

  localparam int CLK_PERIOD = 10;
  localparam int CW         = 10;
  localparam logic [31:0] TAPS = 32'h04C1_1DB7;
  localparam logic [31:0] SEED = 32'hACE1_2345;

  localparam logic [7:0] R_CTRL = 8'h00, R_CORE = 8'h04, R_GEN = 8'h08, R_CNT = 8'h0C,
                         R_WARM = 8'h10, R_STAT = 8'h18, R_IEN = 8'h1C, R_DATA = 8'h20,
                         R_LVL = 8'h24;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        health_fail = 0;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  rng_regfront #(.CNT_W(CW), .FIFO_DEPTH(16)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .health_fail(health_fail), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] adv(input logic [31:0] s);
    logic [31:0] sh;
    sh = s << 1;
    if (s[31]) sh = sh ^ TAPS;
    return sh;
  endfunction

  function automatic logic [31:0] exp_word(input int skip, input int idx);
    logic [31:0] s;
    logic [31:0] w;
    s = SEED;
    w = 0;
    for (int i = 0; i < skip + idx * 32; i++) s = adv(s);
    for (int i = 0; i < 32; i++) begin
      w = {w[30:0], s[31]};
      s = adv(s);
    end
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FIFO-front FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic run_ticks(input int n, input logic [31:0] ctrl);
    wr(R_CTRL, ctrl);
    repeat (n - 1) @(posedge clk);
    wr(R_CTRL, 32'h0);
  endtask

  task automatic restart();
    wr(R_CTRL, 0);
    wr(R_GEN, 1);
    wr(R_CORE, 1);
    wr(R_CORE, 0);
    wr(R_GEN, 0);
    wr(R_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(R_CNT, d);  check("R1 bit count", d, 0);
    rd(R_LVL, d);  check("R1 level", d, 0);
    rd(R_STAT, d); check("R1 status", d, 0);
    rd(R_CTRL, d); check("R1 control", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    restart();
    wr(R_WARM, 0);
    run_ticks(64, 32'h0000_1000);   // R2: only a high bit of the enable field set
    rd(R_CNT, d); check("R2 count after 64 samples", d, 64);
    rd(R_LVL, d); check("R2 level two words", d, 2);
    for (int i = 0; i < 2; i++) begin
      rd(R_DATA, d); check("R3 word order MSB-first", d, exp_word(0, i));
    end
    rd(R_LVL, d); check("R4 level after pops", d, 0);
  endtask

  task automatic t_warmup();
    logic [31:0] d;
    restart();
    wr(R_WARM, 40);
    run_ticks(104, 1);
    rd(R_LVL, d); check("R3 words after discard", d, 2);
    for (int i = 0; i < 2; i++) begin
      rd(R_DATA, d); check("R3 first 40 bits discarded", d, exp_word(40, i));
    end
    rd(R_STAT, d); check("R9 threshold and start bits", d, 32'h0002_0001);
    wr(R_STAT, 32'h0000_0001);
    rd(R_STAT, d); check("R9 write-one clears bit 0 only", d, 32'h0002_0000);
    wr(R_WARM, 0);
  endtask

  task automatic t_empty();
    logic [31:0] d;
    restart();
    rd(R_DATA, d); check("R4 empty read value", d, 0);
    rd(R_LVL, d);  check("R4 empty read level", d, 0);
  endtask

  task automatic t_pause();
    logic [31:0] d;
    restart();
    run_ticks(48, 1);
    rd(R_LVL, d); check("R6 one word after 48", d, 1);
    repeat (20) @(posedge clk);
    rd(R_LVL, d); check("R6 level kept while off", d, 1);
    run_ticks(16, 1);
    rd(R_LVL, d); check("R6 partial word resumed", d, 2);
    for (int i = 0; i < 2; i++) begin
      rd(R_DATA, d); check("R6 stream continuous", d, exp_word(0, i));
    end
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    restart();
    run_ticks(640, 1);
    rd(R_CNT, d); check("R2 count 640", d, 640);
    rd(R_LVL, d); check("R5 level capped", d, 16);
    wr(R_LVL, 32'h0000_0200);
    wr(R_IEN, 32'h0000_0002);
    rd(R_STAT, d); check("R11 level bit live", d & 32'h2, 32'h2);
    wr(R_STAT, 32'h0000_0002);
    rd(R_STAT, d); check("R11 level bit not cleared by write", d & 32'h2, 32'h2);
    check("R11 irq from level", {31'b0, irq}, 1);
    for (int i = 0; i < 16; i++) begin
      rd(R_DATA, d); check("R5 oldest words kept", d, exp_word(0, i));
    end
    rd(R_STAT, d); check("R11 level bit off when empty", d & 32'h2, 0);
    check("R11 irq off", {31'b0, irq}, 0);
    run_ticks(64, 1);
    wr(R_CORE, 1);
    rd(R_LVL, d); check("R7 core reset flushes", d & 32'hFF, 0);
    rd(R_CNT, d); check("R7 core reset clears count", d, 0);
    wr(R_CORE, 0);
    wr(R_LVL, 0);
    wr(R_IEN, 0);
  endtask

  task automatic t_gen_reset();
    logic [31:0] d;
    restart();
    run_ticks(40, 1);       // advance generator
    wr(R_GEN, 1);
    wr(R_CORE, 1);
    wr(R_CORE, 0);
    wr(R_GEN, 0);
    run_ticks(32, 1);
    rd(R_DATA, d); check("R7 generator back at seed", d, exp_word(0, 0));
  endtask

  task automatic t_divider();
    logic [31:0] d;
    restart();
    run_ticks(40, (32'd3 << 13) | 32'd1);
    rd(R_CNT, d); check("R8 divider 3 gives 1 per 4", d, 10);
  endtask

  task automatic t_health();
    logic [31:0] d;
    restart();
    wr(R_IEN, 32'h0000_0020);
    @(negedge clk); health_fail = 1;
    @(negedge clk); health_fail = 0;
    rd(R_STAT, d); check("R10 fail bit", d, 32'h0000_0020);
    check("R11 irq from fail", {31'b0, irq}, 1);
    @(negedge clk); health_fail = 1;
    @(negedge clk); health_fail = 0;
    rd(R_STAT, d); check("R10 lockout bit", d, 32'h8000_0020);
    run_ticks(20, 1);
    rd(R_CNT, d); check("R10 lockout halts sampling", d, 0);
    wr(R_STAT, 32'hFFFF_FFFF);
    rd(R_STAT, d); check("R10 cleared by ones", d, 0);
    check("R11 irq cleared", {31'b0, irq}, 0);
    run_ticks(20, 1);
    rd(R_CNT, d); check("R10 sampling resumes", d, 20);
    wr(R_IEN, 0);
  endtask

  task automatic t_saturate();
    logic [31:0] d;
    restart();
    run_ticks(1100, 1);
    rd(R_CNT, d); check("R12 count saturates", d, 32'd1023);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_basic();
    t_warmup();
    t_empty();
    t_pause();
    t_overflow();
    t_gen_reset();
    t_divider();
    t_health();
    t_saturate();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule